// File: doc/BRIEF.md
# Majority-Gate Ripple Adder

This block adds two unsigned operands and a carry-in using only three-input majority functions and inverters; no exclusive-OR appears anywhere in the datapath. Each bit position computes its carry-out as the majority of its two operand bits and its incoming carry. Its sum bit is then built from nested majority gates. Those gates take the complement of the bit's own carry-out and the complement of the carry that arrives at the bit. The carries ripple from the least significant position upward.

A parameter picks one of two sum formulations. The reduced form uses two majority levels per sum bit. The longer form adds a third level whose extra gates cancel out logically. Both must agree bit for bit with ordinary binary addition. Bit 0 treats the complement of the external carry-in as its "previous inverted carry", so the least significant position follows the same equation as every other bit. The result and carry-out are captured in one register stage, so a result appears one clock after its operands.

Top module: `mg_ripple_adder`

## Requirements
- R1: While `rstN` is low, `sumOut` and `carryOut` are driven to zero at every rising clock edge, whatever the operand inputs are.
- R2: The operands present at a rising edge with `rstN` high determine the outputs after that edge. The outputs do not change before that edge.
- R3: With the two-level sum formulation (`SUM_FORM` = `SUM_TWO_LEVEL`, encoded 0), `sumOut` equals the low `WIDTH` bits of `opA + opB + carryIn`.
- R4: With the three-level sum formulation (`SUM_FORM` = `SUM_THREE_LEVEL`, encoded 1), `sumOut` equals the low `WIDTH` bits of `opA + opB + carryIn`.
- R5: `carryOut` equals bit `WIDTH` of the `WIDTH+1`-bit sum `opA + opB + carryIn`, in both formulations.
- R6: `sumOut[0]` is correct for all eight combinations of `opA[0]`, `opB[0]` and `carryIn`. For example, 2 + 3 with no carry-in gives 5.
- R7: A carry-in of 1 added to an all-ones operand and a zero operand ripples through every bit, giving `sumOut` = 0 and `carryOut` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the result register |
| rstN | input | 1 | Synchronous active-low reset of the result register |
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Registered sum |
| carryOut | output | 1 | Registered carry out of the top bit |

## Verification
A wrong carry in any slice appears in the registered outputs one clock after the operands that exercise it. It corrupts that slice's sum bit, and usually every sum bit above it and `carryOut` as well. A fault in the nested sum gates affects only its own bit, and only for certain operand and carry combinations, so coverage depends on reaching every combination per bit. For that reason the 4-bit instances are driven exhaustively in both formulations. The 16-bit instances take random operands plus a long-ripple vector.

// File: rtl/mg_pkg.sv
package mg_pkg;

  typedef enum logic {
    SUM_TWO_LEVEL   = 1'b0,
    SUM_THREE_LEVEL = 1'b1
  } sumForm_e;

  // Three-input majority: the only logic primitive of the datapath.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (c & a);
  endfunction

endpackage

// File: rtl/mg_bit_slice.sv
module mg_bit_slice #(
  parameter mg_pkg::sumForm_e SUM_FORM = mg_pkg::SUM_TWO_LEVEL
) (
  input  logic a,
  input  logic b,
  input  logic cIn,
  output logic cOut,
  output logic s
);
  import mg_pkg::*;

  logic carryGate;
  logic dNow;
  logic dPrev;
  logic firstLevel;

  always_comb begin
    carryGate  = maj3(a, b, cIn);
    dNow       = ~carryGate;
    dPrev      = ~cIn;
    firstLevel = maj3(a, b, dPrev);
  end

  assign cOut = carryGate;

  generate
    if (SUM_FORM == SUM_THREE_LEVEL) begin : g_threeLevel
      logic midLevel;
      always_comb begin
        midLevel = maj3(firstLevel, carryGate, dNow);
        s        = maj3(midLevel, dNow, cIn);
      end
    end else begin : g_twoLevel
      always_comb s = maj3(firstLevel, dNow, cIn);
    end
  endgenerate

endmodule

// File: rtl/mg_ripple_chain.sv
module mg_ripple_chain #(
  parameter int WIDTH = 16,
  parameter mg_pkg::sumForm_e SUM_FORM = mg_pkg::SUM_TWO_LEVEL
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cIn,
  output logic [WIDTH-1:0] s,
  output logic             cOut
);
  localparam int CW = WIDTH + 1;

  logic [CW-1:0] carry;

  assign carry[0] = cIn;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      mg_bit_slice #(.SUM_FORM(SUM_FORM)) u_slice (
        .a   (a[i]),
        .b   (b[i]),
        .cIn (carry[i]),
        .cOut(carry[i+1]),
        .s   (s[i])
      );
    end
  endgenerate

  assign cOut = carry[CW-1];

endmodule

// File: rtl/mg_result_reg.sv
module mg_result_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sumNext,
  input  logic             carryNext,
  output logic [WIDTH-1:0] sumQ,
  output logic             carryQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ   <= '0;
      carryQ <= 1'b0;
    end else begin
      sumQ   <= sumNext;
      carryQ <= carryNext;
    end
  end
endmodule

// File: rtl/mg_ripple_adder.sv
module mg_ripple_adder #(
  parameter int WIDTH = 16,
  parameter mg_pkg::sumForm_e SUM_FORM = mg_pkg::SUM_TWO_LEVEL
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int RW = WIDTH + 1;

  logic [WIDTH-1:0] chainSum;
  logic             chainCarry;

  mg_ripple_chain #(.WIDTH(WIDTH), .SUM_FORM(SUM_FORM)) u_chain (
    .a   (opA),
    .b   (opB),
    .cIn (carryIn),
    .s   (chainSum),
    .cOut(chainCarry)
  );

  mg_result_reg #(.WIDTH(WIDTH)) u_result (
    .clk      (clk),
    .rstN     (rstN),
    .sumNext  (chainSum),
    .carryNext(chainCarry),
    .sumQ     (sumOut),
    .carryQ   (carryOut)
  );

  // Arithmetic reference for the checks below (not used by the datapath).
  logic [RW-1:0] arithRef;
  assign arithRef = {1'b0, opA} + {1'b0, opB} + RW'(carryIn);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sumOut == '0 && !carryOut));

  generate
    if (SUM_FORM == mg_pkg::SUM_THREE_LEVEL) begin : g_chkThree
      a_r4_three_level_sum: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> sumOut == $past(arithRef[WIDTH-1:0]));
    end else begin : g_chkTwo
      a_r3_two_level_sum: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> sumOut == $past(arithRef[WIDTH-1:0]));
    end
  endgenerate

  a_r5_carry_out: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> carryOut == $past(arithRef[WIDTH]));

  a_r6_lsb_parity: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> sumOut[0] == $past(opA[0] ^ opB[0] ^ carryIn));

  a_r7_full_ripple: assert property (@(posedge clk) disable iff (!rstN)
    (opA == '1 && opB == '0 && carryIn) |=> (sumOut == '0 && carryOut));

endmodule

// File: tb/tb_mg_ripple_adder.sv
module tb_mg_ripple_adder;
  import mg_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [15:0] inA, inB;
  logic        inC;

  logic [3:0]  s4two, s4three;
  logic        c4two, c4three;
  logic [15:0] s16two, s16three;
  logic        c16two, c16three;

  mg_ripple_adder #(.WIDTH(4), .SUM_FORM(SUM_TWO_LEVEL)) dut (
    .clk(clk), .rstN(rstN), .opA(inA[3:0]), .opB(inB[3:0]), .carryIn(inC),
    .sumOut(s4two), .carryOut(c4two));
  mg_ripple_adder #(.WIDTH(4), .SUM_FORM(SUM_THREE_LEVEL)) dutThree4 (
    .clk(clk), .rstN(rstN), .opA(inA[3:0]), .opB(inB[3:0]), .carryIn(inC),
    .sumOut(s4three), .carryOut(c4three));
  mg_ripple_adder #(.WIDTH(16), .SUM_FORM(SUM_TWO_LEVEL)) dutTwo16 (
    .clk(clk), .rstN(rstN), .opA(inA), .opB(inB), .carryIn(inC),
    .sumOut(s16two), .carryOut(c16two));
  mg_ripple_adder #(.WIDTH(16), .SUM_FORM(SUM_THREE_LEVEL)) dutThree16 (
    .clk(clk), .rstN(rstN), .opA(inA), .opB(inB), .carryIn(inC),
    .sumOut(s16three), .carryOut(c16three));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] pA, pB;
  logic        pC;
  bit          havePrev = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    int unsigned e4, e16;
    e4  = int'(pA[3:0]) + int'(pB[3:0]) + int'(pC);
    e16 = int'(pA) + int'(pB) + int'(pC);
    chk("R3 4b two-level sum", 32'(s4two), e4 & 32'hF);
    chk("R5 4b two-level carry", 32'(c4two), (e4 >> 4) & 1);
    chk("R4 4b three-level sum", 32'(s4three), e4 & 32'hF);
    chk("R5 4b three-level carry", 32'(c4three), (e4 >> 4) & 1);
    chk("R3 16b two-level sum", 32'(s16two), e16 & 32'hFFFF);
    chk("R5 16b two-level carry", 32'(c16two), (e16 >> 16) & 1);
    chk("R4 16b three-level sum", 32'(s16three), e16 & 32'hFFFF);
    chk("R5 16b three-level carry", 32'(c16three), (e16 >> 16) & 1);
    chk("R6 lsb two-level", 32'(s4two[0]), 32'(pA[0] ^ pB[0] ^ pC));
    chk("R6 lsb three-level", 32'(s4three[0]), 32'(pA[0] ^ pB[0] ^ pC));
    if (pA == 16'hFFFF && pB == 16'h0 && pC) begin
      chk("R7 16b two-level ripple", {15'b0, c16two, s16two}, 32'h10000);
      chk("R7 16b three-level ripple", {15'b0, c16three, s16three}, 32'h10000);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    if (havePrev) compareAll();
    inA = a; inB = b; inC = c;
    pA = a; pB = b; pC = c;
    havePrev = 1'b1;
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    rstN = 1'b0;
    inA = 16'hFFFF; inB = 16'h1234; inC = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset 4b outputs", {c4three, s4three, c4two, s4two}, 32'h0);
      chk("R1 reset 16b two-level", {c16two, s16two}, 32'h0);
      chk("R1 reset 16b three-level", {c16three, s16three}, 32'h0);
    end
    // Release reset and present 2 + 3; outputs must wait for the next edge.
    rstN = 1'b1;
    inA = 16'd2; inB = 16'd3; inC = 1'b0;
    pA = 16'd2; pB = 16'd3; pC = 1'b0; havePrev = 1'b1;
    #1;
    chk("R2 no change before edge", {c4two, s4two, c16two, s16two}, 32'h0);
    @(negedge clk);
    chk("R2 result after one edge", 32'(s16two), 32'd5);
    chk("R6 2+3 gives 5 two-level", 32'(s4two), 32'd5);
    chk("R6 2+3 gives 5 three-level", 32'(s4three), 32'd5);
    havePrev = 1'b0;
    // Exhaustive 4-bit sweep.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++)
          step(16'(a), 16'(b), c[0]);
    // Long ripple at 16 bits.
    step(16'hFFFF, 16'h0000, 1'b1);
    step(16'h0000, 16'hFFFF, 1'b1);
    step(16'h8000, 16'h8000, 1'b0);
    for (int n = 0; n < 2000; n++)
      step(16'($urandom), 16'($urandom), 1'($urandom));
    @(negedge clk);
    compareAll();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

endmodule